// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers vectored interrupt requests for one processor core and decides when the core should be interrupted. Each request carries an 8-bit vector and a flag that tells a level-triggered source from an edge-triggered one. Three 256-bit registers record which vectors are waiting, which are being serviced, and how each was triggered. A task-priority register lets software hold back low-priority work. A spurious-vector register holds a global enable bit and a fallback vector.

The priority of a vector is its upper nibble, called its class. Higher numbers win. The block derives a processor priority from the task priority and the class of the highest vector in service. It raises `irq` when the best waiting vector's class is strictly above that priority.

The core answers with an acknowledge. The block then returns the chosen vector, or the fallback vector when task priority blocks it, or a "none" flag. The core finishes a handler with an end-of-interrupt command. An INIT command returns all state to its reset values. All register state can be read through plain read ports.

Top module: `vic_prio_ctrl`

## Requirements
- R1: A posted vector v sets pending bit v. It sets trigger bit v when `post_level`=1 and clears it when `post_level`=0. The bits are seen on `vec_rd_data`. `vec_rd_sel` chooses the register: 0 pending, 1 in-service, 2 trigger, 3 reads zero. Word `vec_rd_idx`=v[7:5] holds bit v at position v[4:0].
- R2: A successful acknowledge always picks the highest-numbered pending vector.
- R3: `ppr_rd` equals the task priority when the task class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise it equals that in-service class followed by four zero bits. An empty in-service register counts as class 0.
- R4: `irq` is registered and changes at the same clock edge that samples the event which changed the state. It is 1 only when the enable bit (`svr_rd[8]`) is set and some vector is pending. If processor priority is nonzero, the best pending class must also be strictly greater than the processor-priority class.
- R5: If task priority is nonzero and the highest pending vector is less than or equal to it, an acknowledge returns `svr_rd[7:0]`. In that case the pending and in-service registers stay as they were.
- R6: A normal acknowledge clears the chosen vector's pending bit and sets its in-service bit.
- R7: End-of-interrupt clears only the highest set in-service bit. It does nothing when the in-service register is empty. When end-of-interrupt and acknowledge arrive in the same cycle, the end-of-interrupt is applied first.
- R8: After reset or `init_cmd`, task priority is 0, `svr_rd` is 0x0FF (disabled), `irq` is 0, and the pending, in-service and trigger registers are all zero.
- R9: A write on the 4-bit core port puts its value in task-priority bits 7:4 and clears bits 3:0. `core_tpr_rd` returns task-priority bits 7:4.
- R10: An acknowledge while disabled, or while nothing is pending, sets `ack_none`. Pending state is not changed.
- R11: `ack_done` is 1 for exactly the cycle after each cycle with `ack_req`. `ack_vector` and `ack_none` are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_cmd | input | 1 | Return all state to reset values (overrides every other input) |
| post_valid | input | 1 | Post an interrupt request this cycle |
| post_vector | input | 8 | Vector of the posted request |
| post_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr_en | input | 1 | Write the full task priority |
| tpr_wr_data | input | 8 | Task-priority write value |
| core_tpr_wr_en | input | 1 | Write task priority through the core port (lower precedence than tpr_wr_en) |
| core_tpr_wr_data | input | 4 | Task-priority class from the core |
| svr_wr_en | input | 1 | Write the spurious-vector register |
| svr_wr_data | input | 9 | Bit 8 enable, bits 7:0 fallback vector |
| ack_req | input | 1 | Core acknowledge |
| eoi_cmd | input | 1 | End-of-interrupt |
| vec_rd_sel | input | 2 | Register select for vec_rd_data |
| vec_rd_idx | input | 3 | 32-bit word index for vec_rd_data |
| irq | output | 1 | Interrupt request to the core |
| ack_done | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Returned vector |
| ack_none | output | 1 | No vector could be returned |
| tpr_rd | output | 8 | Task priority |
| core_tpr_rd | output | 4 | Task-priority class |
| svr_rd | output | 9 | Spurious-vector register |
| ppr_rd | output | 8 | Processor priority |
| vec_rd_data | output | 32 | Selected word of the pending, in-service or trigger register |

## Verification
Every vector from 0 to 255 is posted with both trigger levels. This checks for missing or wrongly aliased register bits. The bench then acknowledges all 256 in turn and ends all 256, which shows that the vector chosen and the in-service bit cleared are always the highest ones. A grid of every task class against every in-service class checks the processor-priority choice and the `irq` threshold on both sides of equality. Short directed sequences cover the rest: acknowledges blocked by task priority, acknowledges with the block disabled, an acknowledge and end-of-interrupt in the same cycle, and INIT over loaded state. In the same-cycle case, the two possible orderings would leave different vectors in service.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Selection codes for the vector register read port
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_INSV = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_NONE = 2'd3
  } vec_sel_e;

  // Width of a priority class taken from the top of a vector
  localparam int CLASS_W = 4;
endpackage

// File: rtl/vic_hi_enc.sv
// Highest-set-bit encoder over a wide vector register
module vic_hi_enc #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |bits;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vic_prio_eval.sv
// Processor priority and request decision
module vic_prio_eval
  import vic_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          en,
  input  logic [VW-1:0] tpr,
  input  logic          pend_any,
  input  logic [VW-1:0] pend_hi,
  input  logic          insv_any,
  input  logic [VW-1:0] insv_hi,
  output logic [VW-1:0] ppr,
  output logic          req
);
  logic [CLASS_W-1:0] tcls, icls, pcls, ncls;

  always_comb begin
    tcls = tpr[VW-1 -: CLASS_W];
    icls = insv_any ? insv_hi[VW-1 -: CLASS_W] : '0;
    ppr  = (tcls >= icls) ? tpr : {icls, {(VW-CLASS_W){1'b0}}};
    pcls = ppr[VW-1 -: CLASS_W];
    ncls = pend_hi[VW-1 -: CLASS_W];
    req  = en && pend_any && ((ppr == '0) || (ncls > pcls));
  end
endmodule

// File: rtl/vic_prio_ctrl.sv
module vic_prio_ctrl
  import vic_pkg::*;
#(
  parameter int NVEC   = 256,
  parameter int WORD_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             init_cmd,
  input  logic                             post_valid,
  input  logic [$clog2(NVEC)-1:0]          post_vector,
  input  logic                             post_level,
  input  logic                             tpr_wr_en,
  input  logic [$clog2(NVEC)-1:0]          tpr_wr_data,
  input  logic                             core_tpr_wr_en,
  input  logic [3:0]                       core_tpr_wr_data,
  input  logic                             svr_wr_en,
  input  logic [$clog2(NVEC):0]            svr_wr_data,
  input  logic                             ack_req,
  input  logic                             eoi_cmd,
  input  logic [1:0]                       vec_rd_sel,
  input  logic [$clog2(NVEC/WORD_W)-1:0]   vec_rd_idx,
  output logic                             irq,
  output logic                             ack_done,
  output logic [$clog2(NVEC)-1:0]          ack_vector,
  output logic                             ack_none,
  output logic [$clog2(NVEC)-1:0]          tpr_rd,
  output logic [3:0]                       core_tpr_rd,
  output logic [$clog2(NVEC):0]            svr_rd,
  output logic [$clog2(NVEC)-1:0]          ppr_rd,
  output logic [WORD_W-1:0]                vec_rd_data
);
  localparam int VW = $clog2(NVEC);
  localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};
  localparam logic [VW:0]     SVR_RST = {1'b0, {VW{1'b1}}};

  // State registers
  logic [NVEC-1:0] pend_q, insv_q, trig_q;
  logic [NVEC-1:0] pend_d, insv_d, trig_d;
  logic [VW-1:0]   tpr_q, tpr_d;
  logic [VW:0]     svr_q, svr_d;
  logic            irq_q, ackd_q, ackn_q;
  logic [VW-1:0]   ackv_q, ackv_d, ppr_q;
  logic            ackn_d;
  logic            state_en, tpr_en, svr_en;

  // Encoders on current state
  logic [VW-1:0] pend_hi, insv_hi;
  logic          pend_any, insv_any;
  vic_hi_enc #(.N(NVEC), .IW(VW)) u_pend_cur (.bits(pend_q), .idx(pend_hi), .any(pend_any));
  vic_hi_enc #(.N(NVEC), .IW(VW)) u_insv_cur (.bits(insv_q), .idx(insv_hi), .any(insv_any));

  // Encoders on next state (for registered irq and ppr)
  logic [VW-1:0] pend_hi_n, insv_hi_n, ppr_n;
  logic          pend_any_n, insv_any_n, req_n;
  vic_hi_enc #(.N(NVEC), .IW(VW)) u_pend_nxt (.bits(pend_d), .idx(pend_hi_n), .any(pend_any_n));
  vic_hi_enc #(.N(NVEC), .IW(VW)) u_insv_nxt (.bits(insv_d), .idx(insv_hi_n), .any(insv_any_n));

  vic_prio_eval #(.VW(VW)) u_eval (
    .en(svr_d[VW]), .tpr(tpr_d),
    .pend_any(pend_any_n), .pend_hi(pend_hi_n),
    .insv_any(insv_any_n), .insv_hi(insv_hi_n),
    .ppr(ppr_n), .req(req_n)
  );

  // Acknowledge decision on current state
  logic ack_empty, ack_spur, ack_take, eoi_take;
  always_comb begin
    ack_empty = !svr_q[VW] || !pend_any;
    ack_spur  = !ack_empty && (tpr_q != '0) && (pend_hi <= tpr_q);
    ack_take  = ack_req && !init_cmd && !ack_empty && !ack_spur;
    eoi_take  = eoi_cmd && !init_cmd && insv_any;
  end

  // Next-state logic
  always_comb begin
    pend_d = pend_q;
    insv_d = insv_q;
    trig_d = trig_q;
    if (init_cmd) begin
      pend_d = '0;
      insv_d = '0;
      trig_d = '0;
    end else begin
      if (eoi_take)   insv_d = insv_d & ~(ONE << insv_hi);
      if (ack_take) begin
        pend_d = pend_d & ~(ONE << pend_hi);
        insv_d = insv_d | (ONE << pend_hi);
      end
      if (post_valid) begin
        pend_d = pend_d | (ONE << post_vector);
        if (post_level) trig_d = trig_d | (ONE << post_vector);
        else            trig_d = trig_d & ~(ONE << post_vector);
      end
    end
    state_en = init_cmd || post_valid || ack_take || eoi_take;

    tpr_d = tpr_q;
    if (init_cmd)            tpr_d = '0;
    else if (tpr_wr_en)      tpr_d = tpr_wr_data;
    else if (core_tpr_wr_en) tpr_d = {core_tpr_wr_data, {(VW-CLASS_W){1'b0}}};
    tpr_en = init_cmd || tpr_wr_en || core_tpr_wr_en;

    svr_d = svr_q;
    if (init_cmd)       svr_d = SVR_RST;
    else if (svr_wr_en) svr_d = svr_wr_data;
    svr_en = init_cmd || svr_wr_en;

    ackn_d = ack_req && (init_cmd || ack_empty);
    ackv_d = '0;
    if (ack_req && !init_cmd && !ack_empty)
      ackv_d = ack_spur ? svr_q[VW-1:0] : pend_hi;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      insv_q <= '0;
      trig_q <= '0;
    end else if (state_en) begin
      pend_q <= pend_d;
      insv_q <= insv_d;
      trig_q <= trig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_q <= '0;
    else if (tpr_en) tpr_q <= tpr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      svr_q <= SVR_RST;
    else if (svr_en) svr_q <= svr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      ppr_q  <= '0;
      ackd_q <= 1'b0;
      ackv_q <= '0;
      ackn_q <= 1'b0;
    end else begin
      irq_q  <= req_n;
      ppr_q  <= ppr_n;
      ackd_q <= ack_req;
      ackv_q <= ackv_d;
      ackn_q <= ackn_d;
    end
  end

  // Read ports
  logic [NVEC-1:0] rd_arr;
  always_comb begin
    unique case (vec_sel_e'(vec_rd_sel))
      SEL_PEND: rd_arr = pend_q;
      SEL_INSV: rd_arr = insv_q;
      SEL_TRIG: rd_arr = trig_q;
      default:  rd_arr = '0;
    endcase
    vec_rd_data = rd_arr[vec_rd_idx*WORD_W +: WORD_W];
  end

  assign irq         = irq_q;
  assign ack_done    = ackd_q;
  assign ack_vector  = ackv_q;
  assign ack_none    = ackn_q;
  assign tpr_rd      = tpr_q;
  assign core_tpr_rd = tpr_q[VW-1 -: CLASS_W];
  assign svr_rd      = svr_q;
  assign ppr_rd      = ppr_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NVEC = 256
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    init_cmd,
  input logic                    tpr_wr_en,
  input logic                    core_tpr_wr_en,
  input logic [3:0]              core_tpr_wr_data,
  input logic                    ack_req,
  input logic                    irq,
  input logic                    ack_done,
  input logic                    ack_none,
  input logic [$clog2(NVEC)-1:0] tpr_rd,
  input logic [$clog2(NVEC):0]   svr_rd,
  input logic [$clog2(NVEC)-1:0] ppr_rd
);
  localparam int VW = $clog2(NVEC);

  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (tpr_rd == '0) && (svr_rd == {1'b0, {VW{1'b1}}}) && !irq);

  // R4
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> svr_rd[VW]);

  // R9
  core_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tpr_wr_en && !tpr_wr_en && !init_cmd) |=>
      (tpr_rd == {$past(core_tpr_wr_data), {(VW-4){1'b0}}}));

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_done);

  // R11
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_done && !ack_none);

  // R10
  ack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !svr_rd[VW]) |=> ack_none);

  // R3
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_rd[VW-1 -: 4] >= tpr_rd[VW-1 -: 4]);
endmodule

bind vic_prio_ctrl vic_chk #(.NVEC(NVEC)) u_vic_chk (
  .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd), .tpr_wr_en(tpr_wr_en),
  .core_tpr_wr_en(core_tpr_wr_en), .core_tpr_wr_data(core_tpr_wr_data),
  .ack_req(ack_req), .irq(irq), .ack_done(ack_done), .ack_none(ack_none),
  .tpr_rd(tpr_rd), .svr_rd(svr_rd), .ppr_rd(ppr_rd)
);

// File: tb/tb_vic_prio_ctrl.sv
module tb_vic_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_cmd, post_valid, post_level;
  logic [7:0]  post_vector, tpr_wr_data;
  logic        tpr_wr_en, core_tpr_wr_en, svr_wr_en, ack_req, eoi_cmd;
  logic [3:0]  core_tpr_wr_data;
  logic [8:0]  svr_wr_data;
  logic [1:0]  vec_rd_sel;
  logic [2:0]  vec_rd_idx;
  logic        irq, ack_done, ack_none;
  logic [7:0]  ack_vector, tpr_rd, ppr_rd;
  logic [3:0]  core_tpr_rd;
  logic [8:0]  svr_rd;
  logic [31:0] vec_rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vic_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .init_cmd(init_cmd),
    .post_valid(post_valid), .post_vector(post_vector), .post_level(post_level),
    .tpr_wr_en(tpr_wr_en), .tpr_wr_data(tpr_wr_data),
    .core_tpr_wr_en(core_tpr_wr_en), .core_tpr_wr_data(core_tpr_wr_data),
    .svr_wr_en(svr_wr_en), .svr_wr_data(svr_wr_data),
    .ack_req(ack_req), .eoi_cmd(eoi_cmd),
    .vec_rd_sel(vec_rd_sel), .vec_rd_idx(vec_rd_idx),
    .irq(irq), .ack_done(ack_done), .ack_vector(ack_vector), .ack_none(ack_none),
    .tpr_rd(tpr_rd), .core_tpr_rd(core_tpr_rd), .svr_rd(svr_rd),
    .ppr_rd(ppr_rd), .vec_rd_data(vec_rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #2;
  endtask

  task automatic post(input int v, input bit lvl);
    post_valid = 1'b1; post_vector = 8'(v); post_level = lvl;
    cyc();
    post_valid = 1'b0;
  endtask

  task automatic do_init;
    init_cmd = 1'b1; cyc(); init_cmd = 1'b0;
  endtask

  task automatic set_svr(input int v);
    svr_wr_en = 1'b1; svr_wr_data = 9'(v); cyc(); svr_wr_en = 1'b0;
  endtask

  task automatic set_tpr(input int v);
    tpr_wr_en = 1'b1; tpr_wr_data = 8'(v); cyc(); tpr_wr_en = 1'b0;
  endtask

  task automatic do_ack(output int vec, output int none);
    ack_req = 1'b1; cyc(); ack_req = 1'b0;
    vec = int'(ack_vector); none = int'(ack_none);
  endtask

  task automatic do_eoi;
    eoi_cmd = 1'b1; cyc(); eoi_cmd = 1'b0;
  endtask

  task automatic rdbit(input int sel, input int v, output int b);
    vec_rd_sel = 2'(sel); vec_rd_idx = 3'(v >> 5);
    #1;
    b = int'(vec_rd_data[v & 31]);
  endtask

  task automatic rdall_zero(input int sel, output int nz);
    nz = 0;
    for (int w = 0; w < 8; w++) begin
      vec_rd_sel = 2'(sel); vec_rd_idx = 3'(w);
      #1;
      if (vec_rd_data != 32'h0) nz = 1;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, nn, b, z, exp_ppr, q, exp_irq;
    rst_n = 1'b0; init_cmd = 0; post_valid = 0; post_vector = 0; post_level = 0;
    tpr_wr_en = 0; tpr_wr_data = 0; core_tpr_wr_en = 0; core_tpr_wr_data = 0;
    svr_wr_en = 0; svr_wr_data = 0; ack_req = 0; eoi_cmd = 0;
    vec_rd_sel = 0; vec_rd_idx = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();

    // R8: reset state
    chk("R8 tpr after reset", tpr_rd, 0);
    chk("R8 svr after reset", svr_rd, 'h0FF);
    chk("R8 irq after reset", irq, 0);
    for (int s = 0; s < 3; s++) begin
      rdall_zero(s, z);
      chk("R8 registers empty after reset", z, 0);
    end

    // R1: post every vector with both trigger levels
    for (int i = 0; i < 256; i++) begin
      bit lvl = bit'((i ^ (i >> 3)) & 1);
      post(i, lvl);
      rdbit(0, i, b); chk($sformatf("R1 pending bit %0d", i), b, 1);
      rdbit(2, i, b); chk($sformatf("R1 trigger bit %0d", i), b, int'(lvl));
      post(i, !lvl);
      rdbit(2, i, b); chk($sformatf("R1 trigger flip %0d", i), b, int'(!lvl));
    end
    // R4: disabled block keeps irq low despite pending vectors
    chk("R4 irq low while disabled", irq, 0);

    // R2/R6: acknowledge all, highest first
    set_svr('h1FF);
    chk("R4 irq rises on enable", irq, 1);
    for (int i = 255; i >= 0; i--) begin
      do_ack(v, nn);
      chk("R11 ack_done", ack_done, 1);
      chk($sformatf("R2 ack order %0d", i), v, i);
      chk("R6 ack not none", nn, 0);
      rdbit(0, i, b); chk($sformatf("R6 pending cleared %0d", i), b, 0);
      rdbit(1, i, b); chk($sformatf("R6 in-service set %0d", i), b, 1);
    end
    cyc();
    chk("R11 ack_done drops", ack_done, 0);
    // R10: nothing pending
    do_ack(v, nn);
    chk("R10 ack empty none", nn, 1);

    // R7: end all, highest first
    for (int i = 255; i >= 0; i--) begin
      do_eoi();
      rdbit(1, i, b); chk($sformatf("R7 eoi cleared %0d", i), b, 0);
      if (i > 0) begin
        rdbit(1, i - 1, b); chk($sformatf("R7 eoi kept %0d", i - 1), b, 1);
      end
    end
    do_eoi();
    rdall_zero(1, z);
    chk("R7 eoi on empty", z, 0);
    chk("R4 irq low with nothing pending", irq, 0);

    // R3/R4: grid of task class vs in-service class
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 16; t++) begin
        do_init();
        set_svr('h1FF);
        post(c * 16 + 3, 1'b0);
        do_ack(v, nn);
        chk("R6 grid ack", v, c * 16 + 3);
        set_tpr(t * 16 + 5);
        exp_ppr = (t >= c) ? (t * 16 + 5) : (c * 16);
        chk($sformatf("R3 ppr t=%0d c=%0d", t, c), ppr_rd, exp_ppr);
        chk("R4 irq no pending", irq, 0);
        q = (c * 5 + t * 3) & 15;
        post(q * 16 + 1, 1'b0);
        exp_irq = (q > (exp_ppr >> 4)) ? 1 : 0;
        chk($sformatf("R4 irq q=%0d t=%0d c=%0d", q, t, c), irq, exp_irq);
      end
    end

    // R4: zero processor priority passes class 0, and timing at the edge
    do_init();
    set_svr('h1FF);
    post('h05, 1'b0);
    chk("R4 irq with ppr zero", irq, 1);
    set_svr('h0FF);
    chk("R4 irq drops on disable", irq, 0);

    // R5: spurious acknowledge
    do_init();
    set_svr('h13F);
    set_tpr('h50);
    post('h45, 1'b0);
    do_ack(v, nn);
    chk("R5 spurious vector", v, 'h3F);
    chk("R5 spurious not none", nn, 0);
    rdbit(0, 'h45, b); chk("R5 pending kept", b, 1);
    rdbit(1, 'h45, b); chk("R5 in-service untouched", b, 0);
    post('h50, 1'b0);
    do_ack(v, nn);
    chk("R5 equal to tpr is spurious", v, 'h3F);
    post('h51, 1'b0);
    chk("R4 irq blocked at equal class", irq, 0);
    do_ack(v, nn);
    chk("R5 above tpr accepted", v, 'h51);
    rdbit(1, 'h51, b); chk("R6 in-service after accept", b, 1);

    // R7: eoi and ack together, eoi first
    do_init();
    set_svr('h1FF);
    post('h80, 1'b0);
    do_ack(v, nn);
    post('hA0, 1'b0);
    ack_req = 1'b1; eoi_cmd = 1'b1; cyc(); ack_req = 1'b0; eoi_cmd = 1'b0;
    chk("R7 same-cycle ack vector", ack_vector, 'hA0);
    rdbit(1, 'h80, b); chk("R7 old in-service cleared", b, 0);
    rdbit(1, 'hA0, b); chk("R7 new in-service set", b, 1);

    // R9: core task-priority port
    core_tpr_wr_en = 1'b1; core_tpr_wr_data = 4'hB; cyc(); core_tpr_wr_en = 1'b0;
    chk("R9 core write lands high", tpr_rd, 'hB0);
    chk("R9 core read", core_tpr_rd, 'hB);
    set_tpr('h37);
    chk("R9 core read after full write", core_tpr_rd, 3);

    // R10: disabled with pending
    set_svr('h0AA);
    post('h66, 1'b1);
    do_ack(v, nn);
    chk("R10 disabled none", nn, 1);
    rdbit(0, 'h66, b); chk("R10 pending kept", b, 1);

    // R8: INIT over loaded state
    do_init();
    chk("R8 tpr after init", tpr_rd, 0);
    chk("R8 svr after init", svr_rd, 'h0FF);
    chk("R8 irq after init", irq, 0);
    for (int s = 0; s < 3; s++) begin
      rdall_zero(s, z);
      chk("R8 registers empty after init", z, 0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule